// File: doc/BRIEF.md
# Wait-Mode Clock Enable Controller

This controller decides which clock enables of a small microcontroller run while the CPU waits for an interrupt. The CPU issues a one-cycle wait strobe. A software-owned depth bit is captured on that strobe and picks one of two wait depths.

- **Shallow wait:** the CPU and bus-interface enables drop and the watchdog taps stop. The system clock and the whole peripheral prescaler keep running.
- **Deep wait:** the system clock, the peripheral prescaler and the watchdog taps all stop as well. The oscillator and PLL enables stay high. A timer keeps its run qualifier only in event-counter mode, and a serial channel keeps it only while its shift clock comes from outside.

An accepted interrupt ends either depth. The core enables return in the next cycle with no settling delay.

All gated clocks are modelled as synchronous enables. The level enables are decoded from a registered mode state. The prescaler taps are single-cycle strobes decoded from a free-running counter. That counter freezes while the peripheral tree is stopped and continues from the same value after wake-up.

Top module: `wclk_ctl`

## Requirements
- R1: While reset is active, the mode is run, every level enable (system, CPU, bus interface, peripheral tree, watchdog, oscillator, PLL) is high, and the prescaler counter is zero.
- R2: In run mode, a wait strobe with the depth bit at 0 and no interrupt accept enters shallow wait. From the next cycle, the CPU, bus-interface and watchdog enables are low, while the system and peripheral tree enables stay high.
- R3: In run mode, a wait strobe with the depth bit at 1 and no interrupt accept enters deep wait. From the next cycle, the system, CPU, bus-interface, peripheral tree and watchdog enables are all low, while the oscillator and PLL enables stay high.
- R4: The depth bit is sampled only on the accepted wait strobe. Changing it during a wait has no effect on the enables.
- R5: In either wait depth, an interrupt accept returns the controller to run mode in the next cycle with all level enables high.
- R6: A wait strobe in the same cycle as an interrupt accept does not enter wait. The CPU enable stays high.
- R7: The prescaler counter (12 bits, wrapping) advances by one on each cycle in which the peripheral tree enable is high, and holds otherwise. Tap k (k = 0..12, divide by 2^k) strobes when the tree enable is high and the low k counter bits are all ones.
- R8: The watchdog divide-by-32 and divide-by-512 strobes occur only in run mode, when the low 5 (resp. 9) counter bits are all ones.
- R9: Timer run qualifier i equals its event-counter-mode input in deep wait and is high otherwise. Serial run qualifier j equals its external-clock-select input in deep wait and is high otherwise.
- R10: The mode output encodes run as 0, shallow wait as 1 and deep wait as 2.
- R11: A wait strobe while already waiting, and an interrupt accept while running, leave the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_strobe_i | input | 1 | One-cycle wait request from the CPU |
| stop_sel_i | input | 1 | Software depth bit (1 = deep) |
| irq_accept_i | input | 1 | Interrupt request accepted |
| tmr_event_mode_i | input | 5 | Per-timer event-counter mode flag |
| sio_ext_clk_i | input | 2 | Per-channel external shift clock select |
| osc_en_o | output | 1 | Oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| sys_clk_en_o | output | 1 | System clock enable |
| cpu_clk_en_o | output | 1 | CPU core clock enable |
| biu_clk_en_o | output | 1 | Bus interface clock enable |
| periph_en_o | output | 1 | Peripheral tree enable |
| wdt_en_o | output | 1 | Watchdog tree enable |
| tap_en_o | output | 13 | Prescaler tap strobes, bit k = divide by 2^k |
| wdt_tap32_o | output | 1 | Watchdog divide-by-32 strobe |
| wdt_tap512_o | output | 1 | Watchdog divide-by-512 strobe |
| tmr_run_o | output | 5 | Timer run qualifiers |
| sio_run_o | output | 2 | Serial run qualifiers |
| mode_o | output | 2 | Current mode (0 run, 1 shallow, 2 deep) |

## Verification
Assertions checked on every cycle cover four properties:
- wait entry one cycle after an accepted strobe;
- suppression of entry when an interrupt is accepted alongside the strobe;
- wake-up one cycle after an accept;
- counter hold while the tree is off, and absence of watchdog strobes outside run mode.

Some behaviours only show up in the bench's scenarios against its cycle model:
- the exact tap phases across a full counter wrap;
- resuming from the frozen count;
- the deep-wait qualifier masks;
- that toggling the depth bit mid-wait changes nothing.

// File: rtl/wclk_pkg.sv
package wclk_pkg;
  typedef enum logic [1:0] {
    WM_RUN     = 2'd0,
    WM_SHALLOW = 2'd1,
    WM_DEEP    = 2'd2
  } wmode_e;
endpackage

// File: rtl/wclk_mode_fsm.sv
module wclk_mode_fsm
  import wclk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wait_strobe_i,
  input  logic   stop_sel_i,
  input  logic   irq_accept_i,
  output wmode_e mode_o
);
  wmode_e mode_q;
  wmode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      WM_RUN: begin
        if (wait_strobe_i && !irq_accept_i) begin
          mode_d = stop_sel_i ? WM_DEEP : WM_SHALLOW;
        end
      end
      WM_SHALLOW, WM_DEEP: begin
        if (irq_accept_i) begin
          mode_d = WM_RUN;
        end
      end
      default: mode_d = WM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= WM_RUN;
    else        mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  assert_depth_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == WM_DEEP && !irq_accept_i) |=> (mode_q == WM_DEEP));

  assert_wait_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == WM_SHALLOW && !irq_accept_i) |=> (mode_q == WM_SHALLOW));
endmodule

// File: rtl/wclk_prescaler.sv
module wclk_prescaler #(
  parameter int TAP_LOG2_MAX = 12,
  parameter int WDT_LO_LOG2  = 5,
  parameter int WDT_HI_LOG2  = 9,
  localparam int CNT_W       = TAP_LOG2_MAX,
  localparam int NUM_TAPS    = TAP_LOG2_MAX + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tree_en_i,
  input  logic                wdt_en_i,
  output logic [NUM_TAPS-1:0] tap_o,
  output logic                wdt_lo_o,
  output logic                wdt_hi_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tree_en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    if (k == 0) begin : g_base
      assign tap_o[k] = tree_en_i;
    end else begin : g_div
      assign tap_o[k] = tree_en_i && (&cnt_q[k-1:0]);
    end
  end

  assign wdt_lo_o = wdt_en_i && (&cnt_q[WDT_LO_LOG2-1:0]);
  assign wdt_hi_o = wdt_en_i && (&cnt_q[WDT_HI_LOG2-1:0]);

  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tree_en_i |=> $stable(cnt_q));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tree_en_i |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/wclk_qualify.sv
module wclk_qualify
  import wclk_pkg::*;
#(
  parameter int NUM_TMR = 5,
  parameter int NUM_SIO = 2
) (
  input  wmode_e             mode_i,
  input  logic [NUM_TMR-1:0] tmr_event_mode_i,
  input  logic [NUM_SIO-1:0] sio_ext_clk_i,
  output logic               core_en_o,
  output logic               tree_en_o,
  output logic               wdt_en_o,
  output logic [NUM_TMR-1:0] tmr_run_o,
  output logic [NUM_SIO-1:0] sio_run_o
);
  logic is_deep;

  always_comb begin
    is_deep   = (mode_i == WM_DEEP);
    core_en_o = (mode_i == WM_RUN);
    wdt_en_o  = (mode_i == WM_RUN);
    tree_en_o = !is_deep;
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    assign tmr_run_o[i] = !is_deep || tmr_event_mode_i[i];
  end

  for (genvar j = 0; j < NUM_SIO; j++) begin : g_sio
    assign sio_run_o[j] = !is_deep || sio_ext_clk_i[j];
  end
endmodule

// File: rtl/wclk_ctl.sv
module wclk_ctl
  import wclk_pkg::*;
#(
  parameter int TAP_LOG2_MAX = 12,
  parameter int WDT_LO_LOG2  = 5,
  parameter int WDT_HI_LOG2  = 9,
  parameter int NUM_TMR      = 5,
  parameter int NUM_SIO      = 2,
  localparam int NUM_TAPS    = TAP_LOG2_MAX + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wait_strobe_i,
  input  logic                stop_sel_i,
  input  logic                irq_accept_i,
  input  logic [NUM_TMR-1:0]  tmr_event_mode_i,
  input  logic [NUM_SIO-1:0]  sio_ext_clk_i,
  output logic                osc_en_o,
  output logic                pll_en_o,
  output logic                sys_clk_en_o,
  output logic                cpu_clk_en_o,
  output logic                biu_clk_en_o,
  output logic                periph_en_o,
  output logic                wdt_en_o,
  output logic [NUM_TAPS-1:0] tap_en_o,
  output logic                wdt_tap32_o,
  output logic                wdt_tap512_o,
  output logic [NUM_TMR-1:0]  tmr_run_o,
  output logic [NUM_SIO-1:0]  sio_run_o,
  output logic [1:0]          mode_o
);
  wmode_e mode;
  logic   core_en;
  logic   tree_en;
  logic   wdt_en;

  wclk_mode_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .wait_strobe_i (wait_strobe_i),
    .stop_sel_i    (stop_sel_i),
    .irq_accept_i  (irq_accept_i),
    .mode_o        (mode)
  );

  wclk_qualify #(
    .NUM_TMR (NUM_TMR),
    .NUM_SIO (NUM_SIO)
  ) u_qual (
    .mode_i           (mode),
    .tmr_event_mode_i (tmr_event_mode_i),
    .sio_ext_clk_i    (sio_ext_clk_i),
    .core_en_o        (core_en),
    .tree_en_o        (tree_en),
    .wdt_en_o         (wdt_en),
    .tmr_run_o        (tmr_run_o),
    .sio_run_o        (sio_run_o)
  );

  wclk_prescaler #(
    .TAP_LOG2_MAX (TAP_LOG2_MAX),
    .WDT_LO_LOG2  (WDT_LO_LOG2),
    .WDT_HI_LOG2  (WDT_HI_LOG2)
  ) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .tree_en_i (tree_en),
    .wdt_en_i  (wdt_en),
    .tap_o     (tap_en_o),
    .wdt_lo_o  (wdt_tap32_o),
    .wdt_hi_o  (wdt_tap512_o)
  );

  assign osc_en_o     = 1'b1;
  assign pll_en_o     = 1'b1;
  assign sys_clk_en_o = tree_en;
  assign cpu_clk_en_o = core_en;
  assign biu_clk_en_o = core_en;
  assign periph_en_o  = tree_en;
  assign wdt_en_o     = wdt_en;
  assign mode_o       = mode;

  assert_enter_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WM_RUN && wait_strobe_i && !irq_accept_i) |=> (!cpu_clk_en_o && !wdt_en_o));

  assert_deep_tree_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WM_RUN && wait_strobe_i && stop_sel_i && !irq_accept_i) |=> !sys_clk_en_o);

  assert_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != WM_RUN && irq_accept_i) |=> (cpu_clk_en_o && sys_clk_en_o && wdt_en_o));

  assert_irq_blocks_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WM_RUN && wait_strobe_i && irq_accept_i) |=> cpu_clk_en_o);

  assert_wdt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != WM_RUN) |-> (!wdt_tap32_o && !wdt_tap512_o));
endmodule

// File: tb/wclk_ctl_test.sv
module wclk_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_strobe = 1'b0;
  logic stop_sel = 1'b0;
  logic irq_acc = 1'b0;
  logic [4:0] ev = '0;
  logic [1:0] xclk = '0;

  logic osc_en, pll_en, sys_en, cpu_en, biu_en, per_en, wdt_en;
  logic [NT-1:0] taps;
  logic w32, w512;
  logic [4:0] tmr_run;
  logic [1:0] sio_run;
  logic [1:0] mode;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  string phase = "reset";

  int m_mode = 0;
  int m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wclk_ctl uut (
    .clk(clk), .rst_n(rst_n), .wait_strobe_i(wait_strobe), .stop_sel_i(stop_sel),
    .irq_accept_i(irq_acc), .tmr_event_mode_i(ev), .sio_ext_clk_i(xclk),
    .osc_en_o(osc_en), .pll_en_o(pll_en), .sys_clk_en_o(sys_en),
    .cpu_clk_en_o(cpu_en), .biu_clk_en_o(biu_en), .periph_en_o(per_en),
    .wdt_en_o(wdt_en), .tap_en_o(taps), .wdt_tap32_o(w32), .wdt_tap512_o(w512),
    .tmr_run_o(tmr_run), .sio_run_o(sio_run), .mode_o(mode)
  );

  // Behavioural reference: mode 0 run, 1 shallow, 2 deep; 12-bit count
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0;
      m_cnt  = 0;
    end else begin
      cyc++;
      if (m_mode != 2) m_cnt = (m_cnt + 1) % 4096;
      if (m_mode == 0) begin
        if (wait_strobe && !irq_acc) m_mode = stop_sel ? 2 : 1;
      end else if (irq_acc) begin
        m_mode = 0;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s [%s] cycle %0d: actual %0h expected %0h",
               req, what, phase, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic run, deep;
    logic [NT-1:0] etaps;
    run  = (m_mode == 0);
    deep = (m_mode == 2);
    for (int k = 0; k < NT; k++)
      etaps[k] = !deep && ((m_cnt % (1 << k)) == ((1 << k) - 1));
    chk("R10", "mode", 32'(mode), 32'(m_mode));
    chk("R1 R2 R5", "cpu_en", 32'(cpu_en), 32'(run));
    chk("R2 R5", "biu_en", 32'(biu_en), 32'(run));
    chk("R3 R4", "sys_en", 32'(sys_en), 32'(!deep));
    chk("R3", "periph_en", 32'(per_en), 32'(!deep));
    chk("R2 R3", "wdt_en", 32'(wdt_en), 32'(run));
    chk("R3", "osc_pll", 32'({osc_en, pll_en}), 32'd3);
    chk("R7", "taps", 32'(taps), 32'(etaps));
    chk("R8", "wdt32", 32'(w32), 32'(run && (m_cnt % 32 == 31)));
    chk("R8", "wdt512", 32'(w512), 32'(run && (m_cnt % 512 == 511)));
    chk("R9", "tmr_run", 32'(tmr_run), deep ? 32'(ev) : 32'h1f);
    chk("R9", "sio_run", 32'(sio_run), deep ? 32'(xclk) : 32'h3);
  end

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic strobe(input logic deep_sel);
    stop_sel = deep_sel;
    wait_strobe = 1'b1;
    step(1);
    wait_strobe = 1'b0;
  endtask

  task automatic wake;
    irq_acc = 1'b1;
    step(1);
    irq_acc = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    // R1: reset state observed for several cycles
    step(3);
    rst_n = 1'b1;
    phase = "run R7 R8";
    step(1100);

    phase = "shallow R2";
    strobe(1'b0);
    stop_sel = 1'b0;
    step(40);
    phase = "shallow R4 depth bit toggled";
    stop_sel = 1'b1;
    step(20);
    phase = "shallow R11 strobe ignored";
    strobe(1'b1);
    step(10);
    phase = "wake R5";
    wake();
    stop_sel = 1'b0;
    step(50);

    phase = "deep R3 R9 mask a";
    ev = 5'b10101; xclk = 2'b01;
    strobe(1'b1);
    stop_sel = 1'b0;
    step(30);
    phase = "deep R4 R9 mask b";
    ev = 5'b01010; xclk = 2'b10;
    step(30);
    phase = "deep R11 strobe ignored";
    strobe(1'b0);
    step(10);
    phase = "wake R5 R7 resume";
    wake();
    step(600);

    phase = "R6 same cycle";
    irq_acc = 1'b1;
    strobe(1'b1);
    irq_acc = 1'b0;
    step(20);

    phase = "R11 irq in run";
    wake();
    step(20);

    phase = "back to back wait";
    strobe(1'b1);
    wake();
    strobe(1'b0);
    wake();
    ev = 5'b11111; xclk = 2'b11;
    strobe(1'b1);
    step(5);
    ev = '0; xclk = '0;
    step(5);
    wake();

    phase = "R7 full wrap";
    step(4500);
    finish_run();
  end
endmodule